// File: doc/BRIEF.md
# Card Host Status and Interrupt Register Bank

This block is the software-facing register front end of a memory-card host controller. It stores the configuration words that the command and data engines consume. It keeps a status vector whose event bits latch until software clears them. It ANDs that vector with two independent mask words to drive two interrupt lines. It also decodes a sixteen-word FIFO data window, returns a fixed identification byte sequence, and reports how many 32-bit FIFO words remain for the transfer.

The engines are outside this block and talk to it through strobes and plain level signals. They raise event bits through a set vector. They present their live FIFO flags, the card response, the remaining byte count and the FIFO head word. In return they receive start pulses, FIFO read and write strobes, and a hold level.

The hold level stops card-to-FIFO refill from the moment software pops a FIFO word. It stays asserted until software next reads the status word or the FIFO-count word. That read releases it and emits a one-cycle resume pulse, so a driver that polls status between FIFO reads never sees the FIFO change under it.

Top module: `mmc_status_regbank`

## Requirements
- R1: After rst_ni is released, every stored register, both masks, the status event bits, hold_o, resume_o, the start pulses, irq_o and rdata_o read as zero.
- R2: Word offsets hold: 0x00 power (bits 7:0 kept), 0x04 clock control (7:0), 0x08 argument (31:0), 0x24 data timer (31:0), 0x28 data length (15:0), 0x2C data control (7:0). A write stores only the listed bits, and the dropped upper bits read back as zero.
- R3: A write to 0x0C stores bits 10:0 with bit 10 forced to zero in the stored copy. When the written bit 10 is 1, cmd_start_o pulses for exactly the cycle after the write. A write to 0x2C with bit 0 set pulses data_start_o the same way.
- R4: Status (read at 0x34) is {status_live_i, event bits}. Event bits 10:0 become 1 the cycle after status_set_i has them and stay 1. A set in the same cycle as a clear of that bit wins.
- R5: A write to 0x38 clears each event bit whose bit is 1 in the written value. Written bits above bit 10 have no effect.
- R6: Mask 0 is at 0x3C and mask 1 is at 0x40. irq_o[i] is 1 when status AND mask i is non-zero, evaluated one clock after status or mask changes.
- R7: Reads of word k (k = 0..7) at 0xFE0 + 4k return the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended.
- R8: 0x48 returns (data_cnt_i + 3) >> 2, computed without overflow. 0x30 returns data_cnt_i. 0x10 returns resp_cmd_i. 0x14..0x20 return response words 0..3 from resp_i (word n in bits 32n+31:32n).
- R9: Every word address from 0x80 through 0xBC is the FIFO port. A read there raises fifo_rd_o in the same cycle and returns fifo_rdata_i. A write there raises fifo_wr_o with fifo_wdata_o equal to the written data.
- R10: A FIFO-port read sets hold_o from the next cycle. A read of 0x34 or 0x48 while hold_o is 1 returns its normal value, drops hold_o and pulses resume_o for one cycle. Other reads leave hold_o unchanged, and with hold_o at 0 no resume pulse occurs.
- R11: Reads of unmapped word offsets (including the write-only 0x38) return zero. Writes to them change no register.
- R12: rdata_o is registered: it shows the addressed value the cycle after rd_en_i and holds while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address, word aligned |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| status_set_i | input | 11 | Event set strobes from the engines |
| status_live_i | input | 11 | Live FIFO flags, status bits 21:11 |
| resp_cmd_i | input | 6 | Index of the last response |
| resp_i | input | 128 | Four response words |
| data_cnt_i | input | 16 | Bytes left in the transfer |
| fifo_rdata_i | input | 32 | FIFO head word |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| fifo_wr_o | output | 1 | FIFO push strobe |
| fifo_wdata_o | output | 32 | FIFO push data |
| power_o | output | 8 | Power control |
| clk_ctrl_o | output | 8 | Card clock control |
| cmd_arg_o | output | 32 | Command argument |
| cmd_o | output | 11 | Stored command word |
| cmd_start_o | output | 1 | Command start pulse |
| data_timer_o | output | 32 | Data timeout |
| data_len_o | output | 16 | Transfer length in bytes |
| data_ctrl_o | output | 8 | Data control |
| data_start_o | output | 1 | Data start pulse |
| hold_o | output | 1 | Refill hold |
| resume_o | output | 1 | Refill resume pulse |
| irq_o | output | 2 | Interrupt lines |

## Verification
Corruption of an event bit shows at irq_o two clocks after the fault, and on the next status read one clock after it. A missed or wrong clear leaves an interrupt line high one clock after the clear edge. A hold flag stuck at either value shows at hold_o the cycle after the FIFO read or the releasing read, and a resume pulse is either missing there or appears on an unrelated read. A wrong decode surfaces at rdata_o one cycle after the read, or as a register that changes after a write that should have been ignored.

// File: rtl/mmc_regbank_pkg.sv
package mmc_regbank_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WORD_W = ADDR_W - 2;

  localparam logic [WORD_W-1:0] W_POWER   = 10'd0;
  localparam logic [WORD_W-1:0] W_CLOCK   = 10'd1;
  localparam logic [WORD_W-1:0] W_ARG     = 10'd2;
  localparam logic [WORD_W-1:0] W_CMD     = 10'd3;
  localparam logic [WORD_W-1:0] W_RESPCMD = 10'd4;
  localparam logic [WORD_W-1:0] W_RESP0   = 10'd5;
  localparam logic [WORD_W-1:0] W_RESP1   = 10'd6;
  localparam logic [WORD_W-1:0] W_RESP2   = 10'd7;
  localparam logic [WORD_W-1:0] W_RESP3   = 10'd8;
  localparam logic [WORD_W-1:0] W_DTIMER  = 10'd9;
  localparam logic [WORD_W-1:0] W_DLEN    = 10'd10;
  localparam logic [WORD_W-1:0] W_DCTRL   = 10'd11;
  localparam logic [WORD_W-1:0] W_DCNT    = 10'd12;
  localparam logic [WORD_W-1:0] W_STATUS  = 10'd13;
  localparam logic [WORD_W-1:0] W_CLEAR   = 10'd14;
  localparam logic [WORD_W-1:0] W_MASK0   = 10'd15;
  localparam logic [WORD_W-1:0] W_FCNT    = 10'd18;

  localparam logic [5:0] FIFO_WIN = 6'h02;   // word[9:4]: 0x80..0xBC
  localparam logic [6:0] ID_WIN   = 7'h7F;   // word[9:3]: 0xFE0..0xFFC

  typedef enum logic [4:0] {
    SEL_NONE, SEL_POWER, SEL_CLOCK, SEL_ARG, SEL_CMD, SEL_RESPCMD,
    SEL_RESP, SEL_DTIMER, SEL_DLEN, SEL_DCTRL, SEL_DCNT, SEL_STATUS,
    SEL_CLEAR, SEL_MASK, SEL_FCNT, SEL_FIFO, SEL_ID
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/mmc_reg_decode.sv
module mmc_reg_decode
  import mmc_regbank_pkg::*;
#(
  parameter int N_IRQ = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [2:0]        sub_o
);
  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    sub_o = '0;
    case (word)
      W_POWER:   sel_o = SEL_POWER;
      W_CLOCK:   sel_o = SEL_CLOCK;
      W_ARG:     sel_o = SEL_ARG;
      W_CMD:     sel_o = SEL_CMD;
      W_RESPCMD: sel_o = SEL_RESPCMD;
      W_RESP0, W_RESP1, W_RESP2, W_RESP3: begin
        sel_o = SEL_RESP;
        sub_o = 3'(word[2:0] - 3'd5);
      end
      W_DTIMER:  sel_o = SEL_DTIMER;
      W_DLEN:    sel_o = SEL_DLEN;
      W_DCTRL:   sel_o = SEL_DCTRL;
      W_DCNT:    sel_o = SEL_DCNT;
      W_STATUS:  sel_o = SEL_STATUS;
      W_CLEAR:   sel_o = SEL_CLEAR;
      W_FCNT:    sel_o = SEL_FCNT;
      default: ;
    endcase
    for (int i = 0; i < N_IRQ; i++) begin
      if (word == W_MASK0 + WORD_W'(i)) begin
        sel_o = SEL_MASK;
        sub_o = 3'(i);
      end
    end
    if (word[9:4] == FIFO_WIN) sel_o = SEL_FIFO;
    if (word[9:3] == ID_WIN) begin
      sel_o = SEL_ID;
      sub_o = word[2:0];
    end
  end
endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq #(
  parameter int STAT_W   = 22,
  parameter int STICKY_W = 11,
  parameter int N_IRQ    = 2,
  localparam int LIVE_W  = STAT_W - STICKY_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [STICKY_W-1:0]           set_i,
  input  logic [LIVE_W-1:0]             live_i,
  input  logic                          clr_en_i,
  input  logic [STICKY_W-1:0]           clr_bits_i,
  input  logic [N_IRQ-1:0]              mask_we_i,
  input  logic [STAT_W-1:0]             mask_wdata_i,
  output logic [STAT_W-1:0]             status_o,
  output logic [N_IRQ-1:0][STAT_W-1:0]  mask_o,
  output logic [N_IRQ-1:0]              irq_o
);
  logic [STICKY_W-1:0] sticky_q;
  logic [STICKY_W-1:0] clr_vec;

  assign clr_vec  = clr_en_i ? clr_bits_i : '0;
  assign status_o = {live_i, sticky_q};

  // set has priority so an event in the clearing cycle is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & ~clr_vec) | set_i;
  end

  p_set_sticks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_q & $past(set_i)) == $past(set_i)));
  p_no_self_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((sticky_q & $past(clr_bits_i & ~set_i)) == '0));

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    logic [STAT_W-1:0] mask_r;
    logic              irq_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_r <= '0;
        irq_r  <= 1'b0;
      end else begin
        if (mask_we_i[g]) mask_r <= mask_wdata_i;
        irq_r <= |(status_o & mask_r);
      end
    end
    assign mask_o[g] = mask_r;
    assign irq_o[g]  = irq_r;

    p_irq_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_r == '0) |=> !irq_r);
  end
endmodule

// File: rtl/mmc_fifo_hold.sv
module mmc_fifo_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_rd_i,
  input  logic release_rd_i,
  output logic hold_o,
  output logic resume_o
);
  logic hold_q, resume_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= hold_q && release_rd_i && !fifo_rd_i;
      if (fifo_rd_i)         hold_q <= 1'b1;
      else if (release_rd_i) hold_q <= 1'b0;
    end
  end

  assign hold_o   = hold_q;
  assign resume_o = resume_q;

  p_hold_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_i |=> hold_o);
  p_hold_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && release_rd_i && !fifo_rd_i) |=> (!hold_o && resume_o));
  p_no_spurious_resume_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |=> !resume_o);
endmodule

// File: rtl/mmc_status_regbank.sv
module mmc_status_regbank
  import mmc_regbank_pkg::*;
#(
  parameter int N_IRQ    = 2,
  parameter int STAT_W   = 22,
  parameter int STICKY_W = 11,
  parameter int DLEN_W   = 16,
  parameter int DCNT_W   = 16,
  localparam int LIVE_W  = STAT_W - STICKY_W,
  localparam int MI_W    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int FC_W    = DCNT_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [STICKY_W-1:0]  status_set_i,
  input  logic [LIVE_W-1:0]    status_live_i,
  input  logic [5:0]           resp_cmd_i,
  input  logic [4*DATA_W-1:0]  resp_i,
  input  logic [DCNT_W-1:0]    data_cnt_i,
  input  logic [DATA_W-1:0]    fifo_rdata_i,
  output logic                 fifo_rd_o,
  output logic                 fifo_wr_o,
  output logic [DATA_W-1:0]    fifo_wdata_o,
  output logic [7:0]           power_o,
  output logic [7:0]           clk_ctrl_o,
  output logic [DATA_W-1:0]    cmd_arg_o,
  output logic [10:0]          cmd_o,
  output logic                 cmd_start_o,
  output logic [DATA_W-1:0]    data_timer_o,
  output logic [DLEN_W-1:0]    data_len_o,
  output logic [7:0]           data_ctrl_o,
  output logic                 data_start_o,
  output logic                 hold_o,
  output logic                 resume_o,
  output logic [N_IRQ-1:0]     irq_o
);
  reg_sel_e   sel;
  logic [2:0] sub;

  mmc_reg_decode #(.N_IRQ(N_IRQ)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .sub_o  (sub)
  );

  logic [STAT_W-1:0]            status;
  logic [N_IRQ-1:0][STAT_W-1:0] mask_w;
  logic [N_IRQ-1:0]             mask_we;
  logic                         clr_en;

  assign clr_en = wr_en_i && (sel == SEL_CLEAR);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_mwe
    assign mask_we[g] = wr_en_i && (sel == SEL_MASK) && (sub == 3'(g));
  end

  mmc_status_irq #(.STAT_W(STAT_W), .STICKY_W(STICKY_W), .N_IRQ(N_IRQ)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (status_set_i),
    .live_i       (status_live_i),
    .clr_en_i     (clr_en),
    .clr_bits_i   (wdata_i[STICKY_W-1:0]),
    .mask_we_i    (mask_we),
    .mask_wdata_i (wdata_i[STAT_W-1:0]),
    .status_o     (status),
    .mask_o       (mask_w),
    .irq_o        (irq_o)
  );

  logic release_rd;
  assign fifo_rd_o    = rd_en_i && (sel == SEL_FIFO);
  assign fifo_wr_o    = wr_en_i && (sel == SEL_FIFO);
  assign fifo_wdata_o = wdata_i;
  assign release_rd   = rd_en_i && ((sel == SEL_STATUS) || (sel == SEL_FCNT));

  mmc_fifo_hold u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_rd_i    (fifo_rd_o),
    .release_rd_i (release_rd),
    .hold_o       (hold_o),
    .resume_o     (resume_o)
  );

  logic [7:0]        power_q, clk_q, dctrl_q;
  logic [DATA_W-1:0] arg_q, timer_q;
  logic [10:0]       cmd_q;
  logic [DLEN_W-1:0] dlen_q;
  logic              cmd_start_q, data_start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      power_q      <= '0;
      clk_q        <= '0;
      arg_q        <= '0;
      cmd_q        <= '0;
      timer_q      <= '0;
      dlen_q       <= '0;
      dctrl_q      <= '0;
      cmd_start_q  <= 1'b0;
      data_start_q <= 1'b0;
    end else begin
      cmd_start_q  <= 1'b0;
      data_start_q <= 1'b0;
      if (wr_en_i) begin
        case (sel)
          SEL_POWER:  power_q <= wdata_i[7:0];
          SEL_CLOCK:  clk_q   <= wdata_i[7:0];
          SEL_ARG:    arg_q   <= wdata_i;
          SEL_CMD: begin
            cmd_q       <= {1'b0, wdata_i[9:0]};  // enable is self-clearing
            cmd_start_q <= wdata_i[10];
          end
          SEL_DTIMER: timer_q <= wdata_i;
          SEL_DLEN:   dlen_q  <= wdata_i[DLEN_W-1:0];
          SEL_DCTRL: begin
            dctrl_q      <= wdata_i[7:0];
            data_start_q <= wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end

  assign power_o      = power_q;
  assign clk_ctrl_o   = clk_q;
  assign cmd_arg_o    = arg_q;
  assign cmd_o        = cmd_q;
  assign cmd_start_o  = cmd_start_q;
  assign data_timer_o = timer_q;
  assign data_len_o   = dlen_q;
  assign data_ctrl_o  = dctrl_q;
  assign data_start_o = data_start_q;

  logic [FC_W-1:0]   fcnt_sum;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  assign fcnt_sum = FC_W'(data_cnt_i) + FC_W'(3);

  always_comb begin
    case (sel)
      SEL_POWER:   rd_mux = DATA_W'(power_q);
      SEL_CLOCK:   rd_mux = DATA_W'(clk_q);
      SEL_ARG:     rd_mux = arg_q;
      SEL_CMD:     rd_mux = DATA_W'(cmd_q);
      SEL_RESPCMD: rd_mux = DATA_W'(resp_cmd_i);
      SEL_RESP:    rd_mux = resp_i[{sub[1:0], 5'b00000} +: DATA_W];
      SEL_DTIMER:  rd_mux = timer_q;
      SEL_DLEN:    rd_mux = DATA_W'(dlen_q);
      SEL_DCTRL:   rd_mux = DATA_W'(dctrl_q);
      SEL_DCNT:    rd_mux = DATA_W'(data_cnt_i);
      SEL_STATUS:  rd_mux = DATA_W'(status);
      SEL_MASK:    rd_mux = DATA_W'(mask_w[sub[MI_W-1:0]]);
      SEL_FCNT:    rd_mux = DATA_W'(fcnt_sum >> 2);
      SEL_FIFO:    rd_mux = fifo_rdata_i;
      SEL_ID:      rd_mux = DATA_W'(id_byte(sub));
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  p_rd_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  p_unmapped_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_NONE) |=>
      $stable({power_q, clk_q, arg_q, cmd_q, timer_q, dlen_q, dctrl_q, mask_w}));
  p_fifo_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:6] == 6'h02) |-> fifo_rd_o);
endmodule

// File: tb/tb_mmc_status_regbank.sv
module tb_mmc_status_regbank;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [11:0]  addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [10:0]  set_v = '0, live_v = '0;
  logic [5:0]   resp_cmd = '0;
  logic [127:0] resp = '0;
  logic [15:0]  dcnt = '0;
  logic [31:0]  fifo_rdata = '0;
  logic         fifo_rd, fifo_wr;
  logic [31:0]  fifo_wdata;
  logic [7:0]   power, clk_ctrl, data_ctrl;
  logic [31:0]  cmd_arg, data_timer;
  logic [10:0]  cmd;
  logic [15:0]  data_len;
  logic         cmd_start, data_start, hold, resume;
  logic [1:0]   irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_status_regbank dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .status_set_i(set_v), .status_live_i(live_v),
    .resp_cmd_i(resp_cmd), .resp_i(resp), .data_cnt_i(dcnt), .fifo_rdata_i(fifo_rdata),
    .fifo_rd_o(fifo_rd), .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata),
    .power_o(power), .clk_ctrl_o(clk_ctrl), .cmd_arg_o(cmd_arg), .cmd_o(cmd),
    .cmd_start_o(cmd_start), .data_timer_o(data_timer), .data_len_o(data_len),
    .data_ctrl_o(data_ctrl), .data_start_o(data_start), .hold_o(hold),
    .resume_o(resume), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] id_exp(input int k);
    case (k)
      0: return 8'h81; 1: return 8'h11; 2: return 8'h04; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 hold", 32'(hold), 0);
    chk("R1 rdata", rdata, 0);
    rd(12'h000, 0, "R1 power");
    rd(12'h00C, 0, "R1 cmd");
    rd(12'h03C, 0, "R1 mask0");
    rd(12'h040, 0, "R1 mask1");
    rd(12'h034, 0, "R1 status");
    rd(12'h028, 0, "R1 dlen");

    // R2 config widths
    wr(12'h000, 32'h1234_56A5);
    wr(12'h004, 32'hFFFF_FF3C);
    wr(12'h008, 32'hDEAD_BEEF);
    wr(12'h024, 32'h0BAD_F00D);
    wr(12'h028, 32'hABCD_1234);
    wr(12'h02C, 32'hFFFF_FF96);
    rd(12'h000, 32'hA5, "R2 power");
    rd(12'h004, 32'h3C, "R2 clock");
    rd(12'h008, 32'hDEAD_BEEF, "R2 arg");
    rd(12'h024, 32'h0BAD_F00D, "R2 timer");
    rd(12'h028, 32'h1234, "R2 dlen");
    rd(12'h02C, 32'h96, "R2 dctrl");
    chk("R2 power_o", 32'(power), 32'hA5);
    chk("R2 data_len_o", 32'(data_len), 32'h1234);

    // R3 command and data start strobes
    wr(12'h00C, 32'h0000_0FFF);
    chk("R3 cmd_start pulse", 32'(cmd_start), 1);
    @(negedge clk);
    chk("R3 cmd_start single", 32'(cmd_start), 0);
    rd(12'h00C, 32'h3FF, "R3 cmd enable cleared");
    wr(12'h00C, 32'h0000_0012);
    chk("R3 no start bit10=0", 32'(cmd_start), 0);
    wr(12'h02C, 32'h0000_0005);
    chk("R3 data_start pulse", 32'(data_start), 1);
    @(negedge clk);
    chk("R3 data_start single", 32'(data_start), 0);

    // R4 sticky set, live bits
    live_v = 11'h5A5;
    set_v = 11'h041;
    @(negedge clk);
    set_v = '0;
    rd(12'h034, 32'h002D_2841, "R4 status sticky+live");
    // set and clear of bit 0 in the same cycle: set wins
    @(negedge clk);
    addr = 12'h038; wdata = 32'h0000_0001; wr_en = 1'b1; set_v = 11'h001;
    @(negedge clk);
    wr_en = 1'b0; set_v = '0;
    rd(12'h034, 32'h002D_2841, "R4 set beats clear");

    // R5 clear
    wr(12'h038, 32'hFFFF_F840);
    rd(12'h034, 32'h002D_2801, "R5 clear bit6 only");
    wr(12'h038, 32'h0000_07FF);
    rd(12'h034, 32'h002D_2800, "R5 clear all events");
    live_v = '0;

    // R6 interrupts
    wr(12'h03C, 32'h0000_0004);
    @(negedge clk);
    set_v = 11'h004;
    @(negedge clk);
    set_v = '0;
    chk("R6 irq0 latency", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R6 irq0 asserted", 32'(irq[0]), 1);
    chk("R6 irq1 masked", 32'(irq[1]), 0);
    wr(12'h040, 32'h0000_0004);
    chk("R6 irq1 one cycle after mask", 32'(irq[1]), 0);
    @(negedge clk);
    chk("R6 irq1 asserted", 32'(irq[1]), 1);
    rd(12'h03C, 32'h4, "R6 mask0 readback");
    rd(12'h040, 32'h4, "R6 mask1 readback");
    wr(12'h038, 32'h0000_0004);
    chk("R6 irq0 before drop", 32'(irq[0]), 1);
    @(negedge clk);
    chk("R6 irq cleared", 32'(irq), 0);
    live_v = 11'h200;
    wr(12'h03C, 32'h0010_0000);
    @(negedge clk);
    chk("R6 live bit irq0", 32'(irq), 32'h1);
    live_v = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 live bit dropped", 32'(irq), 0);

    // R7 identification
    for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(4*k), 32'(id_exp(k)), "R7 id byte");

    // R8 counts and responses
    dcnt = 16'd0;    rd(12'h048, 32'd0, "R8 fcnt 0");
    dcnt = 16'd1;    rd(12'h048, 32'd1, "R8 fcnt 1");
    dcnt = 16'd4;    rd(12'h048, 32'd1, "R8 fcnt 4");
    dcnt = 16'd5;    rd(12'h048, 32'd2, "R8 fcnt 5");
    dcnt = 16'hFFFF; rd(12'h048, 32'h4000, "R8 fcnt max");
    rd(12'h030, 32'hFFFF, "R8 dcnt");
    resp_cmd = 6'h2A;
    resp = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    rd(12'h010, 32'h2A, "R8 respcmd");
    rd(12'h014, 32'h1111_1111, "R8 resp0");
    rd(12'h018, 32'h2222_2222, "R8 resp1");
    rd(12'h01C, 32'h3333_3333, "R8 resp2");
    rd(12'h020, 32'h4444_4444, "R8 resp3");

    // R9 FIFO window
    fifo_rdata = 32'hCAFE_0080;
    rd(12'h080, 32'hCAFE_0080, "R9 fifo read low");
    chk("R10 hold after fifo read", 32'(hold), 1);
    @(negedge clk);
    addr = 12'h0BC; rd_en = 1'b1;
    exp_q.push_back(32'hCAFE_00BC); tag_q.push_back("R9 fifo read high");
    fifo_rdata = 32'hCAFE_00BC;
    #1 chk("R9 fifo_rd strobe", 32'(fifo_rd), 1);
    @(negedge clk);
    rd_en = 1'b0;
    #1 chk("R9 fifo_rd idle", 32'(fifo_rd), 0);
    @(negedge clk);
    addr = 12'h0A4; wdata = 32'h5A5A_0A40; wr_en = 1'b1;
    #1 chk("R9 fifo_wr strobe", 32'(fifo_wr), 1);
    chk("R9 fifo_wdata", fifo_wdata, 32'h5A5A_0A40);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    addr = 12'h0C0; rd_en = 1'b1;
    exp_q.push_back(32'h0); tag_q.push_back("R9 beyond window");
    #1 chk("R9 no strobe at 0xC0", 32'(fifo_rd), 0);
    @(negedge clk);
    rd_en = 1'b0;

    // R10 hold and release
    rd(12'h030, 32'hFFFF, "R10 other read");
    chk("R10 hold kept", 32'(hold), 1);
    chk("R10 no resume", 32'(resume), 0);
    rd(12'h034, 32'h0, "R10 status release");
    chk("R10 hold released", 32'(hold), 0);
    chk("R10 resume pulse", 32'(resume), 1);
    @(negedge clk);
    chk("R10 resume single", 32'(resume), 0);
    rd(12'h09C, 32'hCAFE_00BC, "R10 fifo read again");
    chk("R10 hold set again", 32'(hold), 1);
    rd(12'h048, 32'h4000, "R10 fcnt release");
    chk("R10 hold released by fcnt", 32'(hold), 0);
    chk("R10 resume by fcnt", 32'(resume), 1);
    rd(12'h034, 32'h0, "R10 status no hold");
    chk("R10 no resume when idle", 32'(resume), 0);

    // R11 unmapped
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h04C, 32'hFFFF_FFFF);
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h044, 0, "R11 read 0x44");
    rd(12'h038, 0, "R11 read clear reg");
    rd(12'h100, 0, "R11 read 0x100");
    rd(12'h000, 32'hA5, "R11 power untouched");
    rd(12'h03C, 32'h0010_0000, "R11 mask0 untouched");
    rd(12'h040, 32'h4, "R11 mask1 untouched");
    rd(12'h008, 32'hDEAD_BEEF, "R11 arg untouched");
    chk("R11 irq untouched", 32'(irq), 0);

    // R12 read data holds
    rd(12'h024, 32'h0BAD_F00D, "R12 read");
    addr = 12'h000;
    repeat (3) @(negedge clk);
    chk("R12 rdata held", rdata, 32'h0BAD_F00D);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R12 reads pending actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule